// File: doc/BRIEF.md
# Cascaded Interval Timer Bank

The block contains three interval timers. All three run from the processor clock. Each timer is a chain of three stages:

1. A fixed prescaler that divides elapsed processor clocks.
2. An 8-bit divider that counts prescaler rollovers up to a programmable target.
3. A 4-bit output counter that software reads.

Timers 0 and 1 prescale slowly. Timer 2 prescales eight times faster.

The processor core reports how many clocks each of its cycles represents on a small count input. One instruction can therefore move all prescalers forward by several clocks at once. The bus decoder drives the remaining inputs, all one-hot per timer:

- an enable bit for each timer,
- a target write strobe for each timer, with a shared data byte,
- a read strobe for each timer.

A read returns the timer's output count one cycle later and clears the count in the same access. Software usually polls the counts, which is why the count clears on read.

Top module: `interval_timer_bank`

## Requirements
- R1: After synchronous reset, every prescaler, divider and output count is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: The prescalers of timers 0 and 1 roll over once every 128 elapsed clocks. The prescaler of timer 2 rolls over once every 16 elapsed clocks.
- R3: A prescaler accumulates elapsed clocks whether or not its timer is enabled. A disabled timer keeps its divider value and its output count.
- R4: Each prescaler rollover of an enabled timer steps its 8-bit divider by one. When the stepped value equals the target, the divider returns to 0 and the output count goes up by one. A target of 0 acts as 256.
- R5: `adv_clks` (0 to 15) gives the number of clocks elapsed in a cycle. It is added to every prescaler. On a rollover, the prescaler keeps the excess over its period.
- R6: The output count is 4 bits wide and wraps from 15 to 0.
- R7: Bit i of `rd_stb` (at most one bit set) reads timer i. In the next cycle `rd_valid` is 1 and `rd_data` holds timer i's count from before the access. The stored count is cleared.
- R8: In the cycle where a timer's enable bit goes from 0 to 1, its divider and output count are cleared and do not advance.
- R9: If a read and an output-count increment hit the same timer in the same cycle, the read returns the old count and the stored count becomes 1.
- R10: Bit i of `tgt_we` loads `tgt_wdata` into timer i's target. The new target takes part in comparisons from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_clks | input | 4 | Clocks elapsed in this cycle |
| tmr_en | input | 3 | Per-timer enable, bit i = timer i |
| tgt_we | input | 3 | Per-timer target write strobe |
| tgt_wdata | input | 8 | Target value to write |
| rd_stb | input | 3 | Per-timer read-and-clear strobe, one-hot or zero |
| rd_data | output | 4 | Output count returned by the last read |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The assertions assume two things about the inputs:
- `rd_stb` never has more than one bit set.
- `adv_clks` is always below the shortest prescale period, so a prescaler rolls over at most once per cycle.

The stimulus reads one timer at a time, rotating through them. Its elapsed-clock values stay within 0 to 15.

The sweeps cover:
- single-clock stepping,
- a cycling pattern of multi-clock advances,
- reads on every cycle, which force read/increment collisions,
- a target of 0,
- rapid enable toggling.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int NUM_TIMERS = 3;

  function automatic int period_of(input int idx, input int slow, input int fast);
    return (idx == NUM_TIMERS - 1) ? fast : slow;
  endfunction
endpackage

// File: rtl/itb_prescaler.sv
module itb_prescaler #(
  parameter int PERIOD = 128,
  parameter int ADV_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADV_W-1:0] adv_clks,
  output logic             rollover
);
  localparam int CW = $clog2(PERIOD) + 1;
  localparam logic [CW:0] PER = (CW+1)'(PERIOD);

  logic [CW-1:0] acc;
  logic [CW:0]   sum;

  assign sum      = {1'b0, acc} + (CW+1)'(adv_clks);
  assign rollover = (sum >= PER);

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (rollover) acc <= CW'(sum - PER);
    else               acc <= CW'(sum);
  end

  AST_ADV_SHORT: assert property (@(posedge clk) disable iff (rst)
    ((CW+1)'(adv_clks) < PER)); // R5
  AST_PRE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, acc} < PER)); // R5
endmodule

// File: rtl/itb_divider.sv
module itb_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             en,
  input  logic             tgt_we,
  input  logic [DIV_W-1:0] tgt_wdata,
  output logic             hit,
  output logic             restart
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] target;
  logic [DIV_W-1:0] nxt;
  logic             en_q;

  assign restart = en & ~en_q;
  assign nxt     = cnt + 1'b1;
  assign hit     = step & en & ~restart & (nxt == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      target <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en;
      if (tgt_we) target <= tgt_wdata;
      if (restart)        cnt <= '0;
      else if (step & en) cnt <= hit ? '0 : nxt;
    end
  end

  AST_DIV_GATED: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(cnt)); // R3
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == DIV_W'($past(cnt) + 1'b1))); // R4
  AST_EN_RISE_CLR: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> (cnt == '0)); // R8
endmodule

// File: rtl/itb_outcnt.sv
module itb_outcnt #(
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  input  logic             rd,
  output logic [OUT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else          q <= (rd ? '0 : q) + OUT_W'(inc);
  end

  AST_RD_LEAVES_LOW: assert property (@(posedge clk) disable iff (rst)
    rd |=> (q <= OUT_W'(1))); // R9
  AST_OUT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> (q == OUT_W'($past(q) + 1'b1) || q <= OUT_W'(1))); // R6
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itb_pkg::*;
#(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16,
  parameter int DIV_W    = 8,
  parameter int OUT_W    = 4,
  parameter int ADV_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADV_W-1:0]      adv_clks,
  input  logic [NUM_TIMERS-1:0] tmr_en,
  input  logic [NUM_TIMERS-1:0] tgt_we,
  input  logic [DIV_W-1:0]      tgt_wdata,
  input  logic [NUM_TIMERS-1:0] rd_stb,
  output logic [OUT_W-1:0]      rd_data,
  output logic                  rd_valid
);
  logic [OUT_W-1:0] cnt_q [NUM_TIMERS];
  logic [OUT_W-1:0] sel;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam int P = period_of(i, SLOW_DIV, FAST_DIV);
    logic roll, hit, restart;

    itb_prescaler #(.PERIOD(P), .ADV_W(ADV_W)) u_pre (
      .clk(clk), .rst(rst), .adv_clks(adv_clks), .rollover(roll));

    itb_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .step(roll), .en(tmr_en[i]),
      .tgt_we(tgt_we[i]), .tgt_wdata(tgt_wdata),
      .hit(hit), .restart(restart));

    itb_outcnt #(.OUT_W(OUT_W)) u_out (
      .clk(clk), .rst(rst), .inc(hit), .clr(restart),
      .rd(rd_stb[i]), .q(cnt_q[i]));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_TIMERS; i++)
      if (rd_stb[i]) sel = sel | cnt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= |rd_stb;
      if (|rd_stb) rd_data <= sel;
    end
  end

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_stb)); // R7
endmodule

// File: tb/interval_timer_bank_bench.sv
`timescale 1ns/1ps
module interval_timer_bank_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] adv_clks = '0;
  logic [2:0] tmr_en = '0, tgt_we = '0, rd_stb = '0;
  logic [7:0] tgt_wdata = '0;
  logic [3:0] rd_data;
  logic       rd_valid;

  int n_chk = 0, n_bad = 0;
  int m_pre[3], m_s2[3], m_s3[3], m_tgt[3];
  bit m_enp[3];

  always #2.5 clk = ~clk;

  interval_timer_bank u_interval_timer_bank (
    .clk(clk), .rst(rst), .adv_clks(adv_clks), .tmr_en(tmr_en),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic int per(input int i);
    return (i == 2) ? 16 : 128;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One processor cycle: drive at negedge, update model, check after posedge.
  task automatic cyc(input string tag, input int clks, input logic [2:0] en,
                     input logic [2:0] we, input int wd, input logic [2:0] rd);
    int exp_rd = 0;
    adv_clks = 4'(clks); tmr_en = en; tgt_we = we; tgt_wdata = 8'(wd); rd_stb = rd;
    for (int i = 0; i < 3; i++) begin
      int p; bit roll, rise; int inc = 0;
      if (rd[i]) exp_rd = m_s3[i];
      p = m_pre[i] + clks;
      roll = (p >= per(i));
      m_pre[i] = roll ? p - per(i) : p;
      rise = en[i] && !m_enp[i];
      if (rise) m_s2[i] = 0;
      else if (roll && en[i]) begin
        int nx = (m_s2[i] + 1) % 256;
        if (nx == m_tgt[i]) begin m_s2[i] = 0; inc = 1; end
        else m_s2[i] = nx;
      end
      if (rise) m_s3[i] = 0;
      else m_s3[i] = ((rd[i] ? 0 : m_s3[i]) + inc) % 16;
      if (we[i]) m_tgt[i] = wd;
      m_enp[i] = en[i];
    end
    @(posedge clk);
    @(negedge clk);
    if (rd != 0) begin
      chk(tag, int'(rd_valid), 1);
      chk(tag, int'(rd_data), exp_rd);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_pre[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_tgt[i] = 0; m_enp[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk("R1", int'(rd_valid), 0);
    chk("R1", int'(rd_data), 0);
    for (int i = 0; i < 3; i++) cyc("R1", 0, 3'b000, 3'b000, 0, 3'(1 << i));

    // R10: load targets (t0=1, t2=3)
    cyc("R10", 1, 3'b000, 3'b001, 1, 3'b000);
    cyc("R10", 1, 3'b000, 3'b100, 3, 3'b000);
    // R2/R4: single-clock stepping
    for (int k = 0; k < 1200; k++)
      cyc((k % 2) ? "R2" : "R4", 1, 3'b101, 3'b000, 0,
          (k % 41 == 40) ? 3'b100 : ((k % 97 == 96) ? 3'b001 : 3'b000));

    // R9: read timer 2 every cycle with target 1
    cyc("R10", 1, 3'b101, 3'b100, 1, 3'b000);
    for (int k = 0; k < 200; k++) cyc("R9", 1, 3'b101, 3'b000, 0, 3'b100);

    // R6: let the count wrap past 15
    for (int k = 0; k < 16 * 20; k++) cyc("R6", 1, 3'b101, 3'b000, 0, 3'b000);
    cyc("R6", 0, 3'b101, 3'b000, 0, 3'b100);

    // R3: disabled timers keep state while prescalers keep running
    for (int k = 0; k < 300; k++) cyc("R3", 3, 3'b000, 3'b000, 0, 3'b000);
    for (int i = 0; i < 3; i++) cyc("R3", 1, 3'b000, 3'b000, 0, 3'(1 << i));

    // R8: enable edges clear stages, with rapid toggling
    for (int k = 0; k < 600; k++)
      cyc("R8", 15, (k % 23 < 17) ? 3'b111 : 3'b010, 3'b000, 0, 3'(1 << (k % 3)));

    // R5: multi-clock advances, targets 2/1/5
    cyc("R10", 0, 3'b000, 3'b001, 2, 3'b000);
    cyc("R10", 0, 3'b000, 3'b010, 1, 3'b000);
    cyc("R10", 0, 3'b000, 3'b100, 5, 3'b000);
    for (int k = 0; k < 20000; k++)
      cyc("R5", (k * 7) % 16, 3'b111, 3'b000, 0,
          (k % 11 == 10) ? 3'(1 << (k % 3)) : 3'b000);

    // R4: target 0 acts as 256 on timer 2
    cyc("R4", 0, 3'b011, 3'b100, 0, 3'b000);
    for (int k = 0; k < 6000; k++)
      cyc("R4", 15, 3'b111, 3'b000, 0, (k % 900 == 899) ? 3'b100 : 3'b000);
    cyc("R4", 0, 3'b111, 3'b000, 0, 3'b100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule